// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block sits on the host side of a board and writes a configuration bitstream into a target FPGA through that device's 8-bit parallel slave configuration port. When `start` arrives it pulls the program pin low for a fixed number of system clocks. It then waits until the target has pulled its init line low and let it go high again. After that it streams bytes from a local buffer over a valid/ready interface. Each byte goes out on the data bus and is strobed by one rising edge of a configuration clock derived from the system clock.

The block keeps watching the target's status lines while it loads. If init drops during loading, the bitstream was rejected and the load stops with a CRC error. After the last byte the block keeps the configuration clock running with 0xFF on the bus until done is seen high. It then gives a programmed number of extra clock edges, because the target needs them to finish its start-up. Only then does it report success. A watchdog turns a missing init release or a missing done into a timeout. The status lines are passed through synchronizers before they are used.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset and whenever `busy` is low, the pins are inactive: `cfg_prog_n`, `cfg_csel_n` and `cfg_wen_n` are high, `cfg_clk` is low and `s_ready` is low. `busy`, `done_ok`, `crc_error` and `timeout` read 0 after reset.
- R2: A `start` pulse while idle raises `busy` on the next clock and clears all three result flags. It then holds `cfg_prog_n` low for exactly `PROG_HOLD` system clocks.
- R3: A `start` pulse while `busy` is high is ignored. No second program pulse is produced, and the running load finishes with its normal result.
- R4: After the program pin is released, no byte is accepted and `cfg_clk` stays low until `stat_init_n` has been seen low and then high. From that point to the end of the extra clocks, `cfg_csel_n` and `cfg_wen_n` are held low and `cfg_prog_n` is high.
- R5: Every byte accepted from the stream appears on `cfg_d` and is strobed by exactly one rising edge of `cfg_clk`, in stream order. The byte accepted with `s_last` high is the final data byte.
- R6: `cfg_d` changes only while `cfg_clk` is low. Each byte is stable for at least `CLK_HALF` system clocks before its rising edge and until the following falling edge.
- R7: If `stat_init_n` goes low while bytes are being sent or while waiting for done, the load aborts. `crc_error` is set, `busy` falls and the pins return to their inactive levels.
- R8: After the synchronized done line is seen high, `cfg_clk` makes exactly `EXTRA_CLKS` more rising edges. On the falling edge after the last of them, `done_ok` is set and `busy` falls.
- R9: `timeout` is set and the load aborts in two cases. The first is when init is not released within `WAIT_LIMIT` clocks after the program pin is released. The second is when done is not seen within `WAIT_LIMIT` clocks after the clock phase that follows the last byte.
- R10: At most one of `done_ok`, `crc_error` and `timeout` is high at a time. A set flag is only seen while `busy` is low, and it holds until the next accepted `start`.
- R11: Each high phase of `cfg_clk` lasts exactly `CLK_HALF` system clocks. Each low phase lasts at least `CLK_HALF`.
- R12: Padding bytes of 0xFF placed before or after the bitstream are sent like any other byte and do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new load (one-cycle pulse) |
| s_data | input | 8 | Bitstream byte from the local buffer |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | Current byte is the last of the bitstream |
| s_ready | output | 1 | Byte is taken on this clock when `s_valid` is high |
| cfg_prog_n | output | 1 | Program pin to the target, active low |
| cfg_csel_n | output | 1 | Configuration chip select, active low |
| cfg_wen_n | output | 1 | Configuration write enable, active low |
| cfg_clk | output | 1 | Configuration clock; target samples on its rising edge |
| cfg_d | output | 8 | Configuration data bus |
| stat_init_n | input | 1 | Target init line, low while clearing or on CRC error |
| stat_done | input | 1 | Target done line |
| busy | output | 1 | A load is in progress |
| done_ok | output | 1 | Last load completed successfully |
| crc_error | output | 1 | Last load aborted by init going low |
| timeout | output | 1 | Last load aborted by the watchdog |

## Verification
The assertions assume a few things about the inputs. The target drops init only in answer to a program pulse or to a bad bitstream. The status lines move slowly compared with the synchronizer. A byte offered on the stream is held, unchanged, until it is taken. The bench's target model follows these rules: it changes init and done only at falling system-clock edges, after the delays it has chosen; it takes bytes only on `cfg_clk` rising edges while select and write enable are low; and its byte source keeps `s_valid` and `s_data` fixed until a handshake. The sweep covers stream lengths, gaps in `s_valid` and 0xFF padding. On top of the sweep it forces a CRC abort, both watchdog cases and a stray `start` in the middle of a load.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WINIT,
        ST_LOAD,
        ST_WDONE,
        ST_TAIL
    } ldr_state_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_OK,
        RES_CRC,
        RES_TIMEOUT
    } ldr_result_e;

    // one byte waiting for its rising edge
    typedef struct packed {
        logic [7:0] data;
        logic       last;
        logic       full;
    } byte_slot_t;

    localparam logic [7:0] PAD_BYTE = 8'hFF;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= RST_VAL;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RST_VAL}};
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cfg_cclk_tick.sv
module cfg_cclk_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (run)    cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_downcnt.sv
module cfg_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (dec && !zero)  cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HALF    = 2,
    parameter int PROG_HOLD   = 16,
    parameter int EXTRA_CLKS  = 64,
    parameter int WAIT_LIMIT  = 65536,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    output logic       cfg_prog_n,
    output logic       cfg_csel_n,
    output logic       cfg_wen_n,
    output logic       cfg_clk,
    output logic [7:0] cfg_d,
    input  logic       stat_init_n,
    input  logic       stat_done,
    output logic       busy,
    output logic       done_ok,
    output logic       crc_error,
    output logic       timeout
);
    localparam int TMAX = max3(PROG_HOLD, WAIT_LIMIT, EXTRA_CLKS);
    localparam int TW   = $clog2(TMAX + 1);

    ldr_state_e  state_q, state_d;
    ldr_result_e res_q, res_d;
    byte_slot_t  slot_q;
    logic        last_sent_q;
    logic        cclk_q;
    logic [7:0]  dbus_q;
    logic        init_lo_seen_q;

    logic        init_s, done_s;
    logic        tick, tick_run, rise, fall;
    logic        in_load, in_stream, take;
    logic        t_load, t_dec, t_zero;
    logic [TW-1:0] t_val;

    // status lines cross into the system clock domain
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
        .clk(clk), .rst(rst), .d(stat_init_n), .q(init_s)
    );
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst(rst), .d(stat_done), .q(done_s)
    );

    assign in_load   = (state_q == ST_LOAD);
    assign in_stream = in_load || (state_q == ST_WDONE) || (state_q == ST_TAIL);

    // during loading the clock only runs while a byte is held or cclk is high
    assign tick_run = (in_load && (cclk_q || slot_q.full)) ||
                      (state_q == ST_WDONE) || (state_q == ST_TAIL);

    cfg_cclk_tick #(.HALF(CLK_HALF)) u_tick (
        .clk(clk), .rst(rst), .run(tick_run), .clr(!tick_run), .tick(tick)
    );

    assign rise = tick && !cclk_q;
    assign fall = tick &&  cclk_q;

    // take a byte while paused low, or right on a falling edge
    assign s_ready = in_load && ((!cclk_q && !slot_q.full) || (fall && !last_sent_q));
    assign take    = s_ready && s_valid;

    cfg_downcnt #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
        .dec(t_dec), .zero(t_zero)
    );

    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        t_load  = 1'b0;
        t_val   = '0;
        t_dec   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PROG;
                    res_d   = RES_NONE;
                    t_load  = 1'b1;
                    t_val   = TW'(PROG_HOLD - 1);
                end
            end
            ST_PROG: begin
                t_dec = 1'b1;
                if (t_zero) begin
                    state_d = ST_WINIT;
                    t_load  = 1'b1;
                    t_val   = TW'(WAIT_LIMIT - 1);
                end
            end
            ST_WINIT: begin
                t_dec = 1'b1;
                if (init_lo_seen_q && init_s) begin
                    state_d = ST_LOAD;
                end else if (t_zero) begin
                    state_d = ST_IDLE;
                    res_d   = RES_TIMEOUT;
                end
            end
            ST_LOAD: begin
                if (!init_s) begin
                    state_d = ST_IDLE;
                    res_d   = RES_CRC;
                end else if (fall && last_sent_q) begin
                    state_d = ST_WDONE;
                    t_load  = 1'b1;
                    t_val   = TW'(WAIT_LIMIT - 1);
                end
            end
            ST_WDONE: begin
                t_dec = 1'b1;
                if (!init_s) begin
                    state_d = ST_IDLE;
                    res_d   = RES_CRC;
                end else if (done_s) begin
                    state_d = ST_TAIL;
                    t_load  = 1'b1;
                    t_val   = TW'(EXTRA_CLKS);
                end else if (t_zero) begin
                    state_d = ST_IDLE;
                    res_d   = RES_TIMEOUT;
                end
            end
            ST_TAIL: begin
                t_dec = rise;
                if (t_zero && fall) begin
                    state_d = ST_IDLE;
                    res_d   = RES_OK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            res_q          <= RES_NONE;
            slot_q         <= '0;
            last_sent_q    <= 1'b0;
            cclk_q         <= 1'b0;
            dbus_q         <= PAD_BYTE;
            init_lo_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;

            if (state_d == ST_IDLE || !in_stream) cclk_q <= 1'b0;
            else if (tick)                        cclk_q <= !cclk_q;

            if (state_q == ST_IDLE && start) begin
                slot_q         <= '0;
                last_sent_q    <= 1'b0;
                init_lo_seen_q <= 1'b0;
                dbus_q         <= PAD_BYTE;
            end else begin
                if ((state_q == ST_PROG || state_q == ST_WINIT) && !init_s)
                    init_lo_seen_q <= 1'b1;
                if (in_load) begin
                    if (rise && slot_q.last) last_sent_q <= 1'b1;
                    if (take) begin
                        slot_q <= '{data: s_data, last: s_last, full: 1'b1};
                        dbus_q <= s_data;
                    end else if (fall) begin
                        slot_q.full <= 1'b0;
                        if (last_sent_q) dbus_q <= PAD_BYTE;
                    end
                end
            end
        end
    end

    assign cfg_prog_n = (state_q != ST_PROG);
    assign cfg_csel_n = !in_stream;
    assign cfg_wen_n  = !in_stream;
    assign cfg_clk    = cclk_q;
    assign cfg_d      = dbus_q;
    assign busy       = (state_q != ST_IDLE);
    assign done_ok    = (res_q == RES_OK);
    assign crc_error  = (res_q == RES_CRC);
    assign timeout    = (res_q == RES_TIMEOUT);

endmodule

// File: rtl/cfg_par_loader_chk.sv
module cfg_par_loader_chk #(
    parameter int CLK_HALF  = 2,
    parameter int PROG_HOLD = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       s_ready,
    input logic       cfg_prog_n,
    input logic       cfg_csel_n,
    input logic       cfg_wen_n,
    input logic       cfg_clk,
    input logic [7:0] cfg_d,
    input logic       busy,
    input logic       done_ok,
    input logic       crc_error,
    input logic       timeout
);
    logic [15:0] hi_cnt;
    logic [15:0] prog_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= '0;
            prog_lo <= '0;
        end else begin
            hi_cnt  <= cfg_clk     ? hi_cnt + 1'b1  : '0;
            prog_lo <= !cfg_prog_n ? prog_lo + 1'b1 : '0;
        end
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cfg_prog_n && cfg_csel_n && cfg_wen_n && !cfg_clk && !s_ready));

    a_r2_prog_width: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_prog_n) |-> (prog_lo == 16'(PROG_HOLD)));

    a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_prog_n) |=> cfg_prog_n);

    a_r4_ready_gated: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (cfg_prog_n && !cfg_csel_n && !cfg_wen_n));

    a_r6_data_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_d) |-> !cfg_clk);

    a_r11_high_phase: assert property (@(posedge clk) disable iff (rst)
        ($fell(cfg_clk) && !cfg_csel_n) |-> (hi_cnt == 16'(CLK_HALF)));

    a_r10_one_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_ok, crc_error, timeout}));

    a_r10_result_idle: assert property (@(posedge clk) disable iff (rst)
        (done_ok || crc_error || timeout) |-> !busy);

endmodule

bind cfg_par_loader cfg_par_loader_chk #(
    .CLK_HALF(CLK_HALF),
    .PROG_HOLD(PROG_HOLD)
) u_chk (.*);

// File: tb/test_cfg_par_loader.sv
module test_cfg_par_loader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 2;
    localparam int PH    = 16;
    localparam int EXTRA = 8;
    localparam int WL    = 300;
    localparam int SYNC  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       cfg_prog_n, cfg_csel_n, cfg_wen_n, cfg_clk;
    logic [7:0] cfg_d;
    logic       t_init_n = 1'b1;
    logic       t_done = 1'b0;
    logic       busy, done_ok, crc_error, timeout;

    cfg_par_loader #(
        .CLK_HALF(HALF), .PROG_HOLD(PH), .EXTRA_CLKS(EXTRA),
        .WAIT_LIMIT(WL), .SYNC_STAGES(SYNC)
    ) i_cfg_par_loader (
        .clk(clk), .rst(rst), .start(start),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .cfg_prog_n(cfg_prog_n), .cfg_csel_n(cfg_csel_n), .cfg_wen_n(cfg_wen_n),
        .cfg_clk(cfg_clk), .cfg_d(cfg_d),
        .stat_init_n(t_init_n), .stat_done(t_done),
        .busy(busy), .done_ok(done_ok), .crc_error(crc_error), .timeout(timeout)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] src [0:15];
    logic [7:0] rx  [0:127];
    int  nsrc, nrx, total, crc_at, tail_cnt, prog_lo, hi_run, hw_bad, d_bad;
    int  dly_cnt, arm_cnt;
    bit  done_en, hold_init, released, early, tail_arm, done_pend, crc_pend;
    time last_chg = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prep();
        nrx = 0; tail_cnt = 0; prog_lo = 0; hi_run = 0; hw_bad = 0; d_bad = 0;
        early = 0; released = 0; tail_arm = 0; arm_cnt = 0;
        done_pend = 0; crc_pend = 0; crc_at = 0; done_en = 1; hold_init = 0;
    endtask

    // exp: 0 success, 1 crc abort, 2 timeout
    task automatic do_run(input int len, input int gap, input int pad, input int poke,
                          input int crcat, input int den, input int hinit, input int exp);
        int idx;
        int gapc;
        int g;
        bit took;
        bit poked;
        int mism;
        nsrc = 0;
        if (pad != 0) begin src[0] = 8'hFF; src[1] = 8'hFF; nsrc = 2; end
        for (int i = 0; i < len; i++) begin
            src[nsrc] = 8'((len * 37 + i * 11 + gap * 5 + 1) & 255);
            nsrc++;
        end
        if (pad != 0) begin src[nsrc] = 8'hFF; nsrc++; end
        prep();
        total = nsrc; crc_at = crcat; done_en = (den != 0); hold_init = (hinit != 0);

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        chk("R2 flags cleared", int'(done_ok) + int'(crc_error) + int'(timeout), 0);

        idx = 0; gapc = 0; g = 0; poked = 0;
        while (busy && idx < nsrc && g < 5000) begin
            if (gapc > 0) begin
                s_valid = 1'b0; gapc--;
            end else begin
                s_valid = 1'b1; s_data = src[idx]; s_last = (idx == nsrc - 1);
            end
            start = (poke != 0) && (idx == 1) && !poked;
            if (start) poked = 1;
            #1;
            took = s_valid && s_ready;
            @(negedge clk);
            start = 1'b0;
            g++;
            if (took) begin idx++; gapc = gap; end
        end
        s_valid = 1'b0; s_last = 1'b0;
        while (busy && g < 5000) begin @(negedge clk); g++; end
        chk("R9 run ends", int'(g < 5000), 1);
        @(negedge clk);

        chk("R10 result flags", {29'd0, done_ok, crc_error, timeout},
            (exp == 0) ? 4 : (exp == 1) ? 2 : 1);
        chk("R1 pins released", {29'd0, cfg_prog_n, cfg_csel_n, cfg_wen_n}, 7);
        chk("R4 no early byte", int'(early), 0);
        if (exp == 0) begin
            mism = 0;
            for (int i = 0; i < nsrc; i++) if (rx[i] != src[i]) mism++;
            chk("R5 R12 byte order", mism, 0);
            chk("R5 byte count", nrx, nsrc);
            chk("R2 R3 program width", prog_lo, PH);
            chk("R8 extra clocks", tail_cnt, EXTRA);
            chk("R11 high phase", hw_bad, 0);
            chk("R6 data setup", d_bad, 0);
        end else if (exp == 1) begin
            chk("R7 stopped early", int'(nrx < nsrc), 1);
        end else if (hinit != 0) begin
            chk("R9 R4 nothing sent", nrx, 0);
        end
    endtask

    initial begin
        fork
            forever begin
                @(negedge cfg_prog_n);
                @(negedge clk);
                t_done = 1'b0; t_init_n = 1'b0;
                @(posedge cfg_prog_n);
                repeat (4) @(negedge clk);
                if (!hold_init) begin t_init_n = 1'b1; released = 1; end
            end
            forever begin
                @(posedge cfg_clk);
                if (!cfg_csel_n && !cfg_wen_n && !t_done && t_init_n) begin
                    if ($time - last_chg < HALF * CLK_PERIOD) d_bad++;
                    if (nrx < 128) rx[nrx] = cfg_d;
                    nrx++;
                    if (crc_at != 0 && nrx == crc_at) crc_pend = 1;
                    if (done_en && nrx == total) begin done_pend = 1; dly_cnt = 3; end
                end else if (tail_arm) begin
                    tail_cnt++;
                end
            end
            forever begin
                @(cfg_d);
                last_chg = $time;
            end
            forever begin
                @(negedge clk);
                if (!cfg_prog_n) prog_lo++;
                if (cfg_clk) hi_run++;
                else begin
                    if (hi_run != 0 && hi_run != HALF) hw_bad++;
                    hi_run = 0;
                end
                if (s_ready && !released) early = 1;
                if (crc_pend) begin t_init_n = 1'b0; crc_pend = 0; end
                if (arm_cnt > 0) begin
                    arm_cnt--;
                    if (arm_cnt == 0) tail_arm = 1;
                end
                if (done_pend) begin
                    if (dly_cnt == 0) begin
                        t_done = 1'b1; done_pend = 0; arm_cnt = SYNC + 1;
                    end else begin
                        dly_cnt--;
                    end
                end
            end
        join_none
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        prep();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset pins", {27'd0, cfg_prog_n, cfg_csel_n, cfg_wen_n, cfg_clk, s_ready}, 28);
        chk("R1 reset status", {28'd0, busy, done_ok, crc_error, timeout}, 0);

        for (int len = 1; len <= 5; len++)
            for (int gap = 0; gap <= 2; gap++)
                for (int pad = 0; pad <= 1; pad++)
                    do_run(len, gap, pad, (len == 3 && gap == 1 && pad == 0) ? 1 : 0,
                           0, 1, 0, 0);

        // R7 init low after two bytes
        do_run(6, 0, 0, 0, 2, 1, 0, 1);
        // R9 init never released
        do_run(3, 0, 0, 0, 0, 1, 1, 2);
        // R9 done never rises
        do_run(3, 1, 0, 0, 0, 0, 0, 2);
        // R3 stray start plus recovery after aborts
        do_run(4, 0, 1, 1, 0, 1, 0, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule